// File: doc/BRIEF.md
# Interrupt Cause Vector Router

This block takes four interrupt causes and delivers them either as level signals on a bus of interrupt wires or as memory write requests that carry a message. The causes are the command queue, the page request queue, the fault queue and the performance-counter overflow. Each cause has one pending bit. A source sets it with a one-cycle pulse, and software clears it. Software also writes a vector register that gives every cause a vector number. It can give each cause its own output, send all causes to one output, or let any subset share an output.

In wired mode, the vector number selects one wire of the output bus. In message mode, the vector number indexes a table of address/data entries. Each entry also has a mask bit. A newly raised cause queues one message. The block sends queued messages one at a time over a valid/ready port. No cause has a fixed priority: after each send, a round-robin pointer picks the next cause. The pending bit records only the cause. Software finds the detailed reason in the status register of the source.

Top module: `irq_vec_router`

## Requirements
- R1: After reset, every pending bit reads 0, every wire output is low, `msg_valid` is low, and every table entry reads 0 with its mask bit clear.
- R2: A pulse on `src_pulse[c]` sets the pending bit of cause c. Writing register 0x01 clears every pending bit whose data bit is 1. When a pulse and a clear reach the same bit in the same cycle, the bit stays set. Register 0x01 reads the pending bits in bits 3:0. The cause index is 0 for command, 1 for page request, 2 for fault and 3 for performance overflow.
- R3: In wired mode (register 0x00 bit 0 = 0), wire w is high exactly while at least one cause is pending, has its enable bit set, and has vector w. The enable bits are register 0x03 bits 3:0. The vector of cause c is register 0x02 bits 4c+3:4c. Several causes may share a wire.
- R4: While message mode is active (register 0x00 bit 0 = 1), every wire output is low, even with causes pending.
- R5: In message mode, a pulse to a cause whose pending bit is 0 queues exactly one message. A pulse to a cause that is already pending queues nothing. Entering message mode queues nothing for causes that are already pending.
- R6: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` keep their values. The address and data come from the table entry that the cause's vector selects.
- R7: A cause is sent only if it is queued, still pending, enabled, and its table entry is unmasked. A masked entry holds the message back until the entry is unmasked. If the pending bit is cleared first, the message is dropped.
- R8: After a handshake for cause c, `msg_valid` is low for one cycle. The next message goes to the first eligible cause, searching upward from c+1 and wrapping around.
- R9: Register 0x02 reads back exactly the value software last wrote. No hardware activity changes it.
- R10: Table entry i sits at word address 0x40+4i. Offset 0 holds address bits 31:0, offset 1 holds address bits 63:32, offset 2 holds the data, and offset 3 bit 0 holds the mask. Each word reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 4 | Set pulse, one bit per cause |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| wire_irq | output | 16 | Wired interrupt outputs, one per vector |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write request accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Two things can happen to the same cause in the same cycle. A source pulse can meet a software clear of that pending bit. A handshake can retire a queued message while the next search begins. The bench drives a pulse and a clear write into one cycle, and it pulses all four causes together while the ready signal stays high. A behavioural model runs alongside the design and is compared on every clock for wires, valid, address and data. Separate checks confirm that the pending bit survives the clash, and that the recorded send order follows the round-robin rule.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
   localparam int NUM_CAUSE = 4;
   localparam int CAUSE_W   = 2;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_CMD   = 2'd0,
      CAUSE_PAGE  = 2'd1,
      CAUSE_FAULT = 2'd2,
      CAUSE_PERF  = 2'd3
   } cause_e;

   localparam logic [7:0] REG_CTRL = 8'h00;
   localparam logic [7:0] REG_PEND = 8'h01;
   localparam logic [7:0] REG_VEC  = 8'h02;
   localparam logic [7:0] REG_EN   = 8'h03;
   localparam logic [7:0] TBL_BASE = 8'h40;

   localparam logic [1:0] FLD_ALO  = 2'd0;
   localparam logic [1:0] FLD_AHI  = 2'd1;
   localparam logic [1:0] FLD_DATA = 2'd2;
   localparam logic [1:0] FLD_MASK = 2'd3;
endpackage

// File: rtl/irqr_pending.sv
module irqr_pending
   import irqr_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CAUSE-1:0] src_pulse,
   input  logic [NUM_CAUSE-1:0] clr,
   input  logic                 msg_mode,
   input  logic                 sent,
   input  logic [CAUSE_W-1:0]   sent_cause,
   output logic [NUM_CAUSE-1:0] pending,
   output logic [NUM_CAUSE-1:0] queued
);
   logic [NUM_CAUSE-1:0] pend_n, rise, sent_mask, queued_n;

   always_comb begin
      pend_n    = (pending & ~clr) | src_pulse;
      rise      = src_pulse & ~pending;
      sent_mask = sent ? (NUM_CAUSE'(1) << sent_cause) : '0;
      queued_n  = ((queued & ~sent_mask) | (msg_mode ? rise : '0)) & pend_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= '0;
         queued  <= '0;
      end else begin
         pending <= pend_n;
         queued  <= queued_n;
      end
   end

   for (genvar c = 0; c < NUM_CAUSE; c++) begin : g_chk
      // R2
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         src_pulse[c] |=> pending[c]);
      // R5
      rise_queues_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (msg_mode && src_pulse[c] && !pending[c]) |=> queued[c]);
   end
endmodule

// File: rtl/irqr_wired_map.sv
module irqr_wired_map
   import irqr_pkg::*;
#(
   parameter int VEC_W = 4,
   localparam int NUM_WIRE = 1 << VEC_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CAUSE-1:0]       pending,
   input  logic [NUM_CAUSE-1:0]       enable,
   input  logic [NUM_CAUSE*VEC_W-1:0] vec,
   input  logic                       msg_mode,
   output logic [NUM_WIRE-1:0]        wire_irq
);
   logic [NUM_WIRE-1:0] hit;

   always_comb begin
      hit = '0;
      for (int w = 0; w < NUM_WIRE; w++)
         for (int c = 0; c < NUM_CAUSE; c++)
            if (pending[c] && enable[c] && vec[c*VEC_W +: VEC_W] == VEC_W'(w))
               hit[w] = 1'b1;
   end

   assign wire_irq = msg_mode ? '0 : hit;

   // R4
   wired_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_mode |-> (wire_irq == '0));
endmodule

// File: rtl/irqr_msg_table.sv
module irqr_msg_table #(
   parameter int VEC_W  = 4,
   parameter int ADDR_W = 64,
   parameter int DATA_W = 32,
   localparam int DEPTH = 1 << VEC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [VEC_W-1:0]  wr_idx,
   input  logic [1:0]        wr_field,
   input  logic [31:0]       wr_data,
   input  logic [VEC_W-1:0]  rd_idx,
   input  logic [1:0]        rd_field,
   output logic [31:0]       rd_data,
   output logic [DEPTH-1:0]  mask_vec,
   input  logic [VEC_W-1:0]  sel_idx,
   output logic [ADDR_W-1:0] sel_addr,
   output logic [DATA_W-1:0] sel_data
);
   import irqr_pkg::*;

   logic [ADDR_W-1:0] addr_mem [DEPTH];
   logic [DATA_W-1:0] data_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            addr_mem[i] <= '0;
            data_mem[i] <= '0;
         end
         mask_vec <= '0;
      end else if (wr_en) begin
         unique case (wr_field)
            FLD_ALO:  addr_mem[wr_idx][31:0]        <= wr_data;
            FLD_AHI:  addr_mem[wr_idx][ADDR_W-1:32] <= wr_data[ADDR_W-33:0];
            FLD_DATA: data_mem[wr_idx]              <= wr_data[DATA_W-1:0];
            default:  mask_vec[wr_idx]              <= wr_data[0];
         endcase
      end
   end

   always_comb begin
      unique case (rd_field)
         FLD_ALO:  rd_data = addr_mem[rd_idx][31:0];
         FLD_AHI:  rd_data = 32'(addr_mem[rd_idx][ADDR_W-1:32]);
         FLD_DATA: rd_data = 32'(data_mem[rd_idx]);
         default:  rd_data = {31'd0, mask_vec[rd_idx]};
      endcase
   end

   assign sel_addr = addr_mem[sel_idx];
   assign sel_data = data_mem[sel_idx];
endmodule

// File: rtl/irqr_msg_arb.sv
module irqr_msg_arb
   import irqr_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 msg_mode,
   input  logic [NUM_CAUSE-1:0] eligible,
   output logic [CAUSE_W-1:0]   pick,
   input  logic [ADDR_W-1:0]    pick_addr,
   input  logic [DATA_W-1:0]    pick_data,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [ADDR_W-1:0]    msg_addr,
   output logic [DATA_W-1:0]    msg_data,
   output logic                 sent,
   output logic [CAUSE_W-1:0]   sent_cause
);
   logic [CAUSE_W-1:0] ptr_q, cand;
   logic               found;

   always_comb begin
      found = 1'b0;
      pick  = ptr_q;
      for (int k = 0; k < NUM_CAUSE; k++) begin
         cand = CAUSE_W'(ptr_q + CAUSE_W'(k));
         if (!found && eligible[cand]) begin
            found = 1'b1;
            pick  = cand;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid  <= 1'b0;
         ptr_q      <= '0;
         sent_cause <= '0;
         msg_addr   <= '0;
         msg_data   <= '0;
      end else if (!msg_valid) begin
         if (msg_mode && found) begin
            msg_valid  <= 1'b1;
            sent_cause <= pick;
            msg_addr   <= pick_addr;
            msg_data   <= pick_data;
         end
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
         ptr_q     <= CAUSE_W'(sent_cause + 1'b1);
      end
   end

   assign sent = msg_valid && msg_ready;

   // R6
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
   // R8
   gap_after_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready) |=> !msg_valid);
endmodule

// File: rtl/irq_vec_router.sv
module irq_vec_router
   import irqr_pkg::*;
#(
   parameter int VEC_W  = 4,
   parameter int ADDR_W = 64,
   parameter int DATA_W = 32,
   parameter int REG_AW = 8,
   localparam int NUM_WIRE = 1 << VEC_W,
   localparam int TBL_N    = 1 << VEC_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CAUSE-1:0] src_pulse,
   input  logic                 reg_we,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic [NUM_WIRE-1:0]  wire_irq,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [ADDR_W-1:0]    msg_addr,
   output logic [DATA_W-1:0]    msg_data
);
   if (VEC_W < 1 || VEC_W > 5) begin : g_bad_vec
      $error("VEC_W must lie in 1..5");
   end
   if (ADDR_W <= 32 || ADDR_W > 64) begin : g_bad_addr
      $error("ADDR_W must lie in 33..64");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
      $error("DATA_W must lie in 1..32");
   end
   if (NUM_CAUSE * VEC_W > 32) begin : g_bad_pack
      $error("vector fields exceed one register word");
   end
   if (REG_AW != 8) begin : g_bad_reg
      $error("REG_AW must be 8 for this register layout");
   end

   logic                       mode_q;
   logic [NUM_CAUSE*VEC_W-1:0] vec_q;
   logic [NUM_CAUSE-1:0]       en_q, clr, pending, queued, eligible;
   logic [REG_AW-1:0]          tbl_off;
   logic                       tbl_hit;
   logic [TBL_N-1:0]           mask_vec;
   logic [31:0]                tbl_rdata;
   logic [CAUSE_W-1:0]         pick, sent_cause;
   logic [ADDR_W-1:0]          pick_addr;
   logic [DATA_W-1:0]          pick_data;
   logic                       sent;

   assign tbl_off = reg_addr - TBL_BASE;
   assign tbl_hit = (reg_addr >= TBL_BASE) && (tbl_off < REG_AW'(4 * TBL_N));
   assign clr     = (reg_we && reg_addr == REG_PEND) ? reg_wdata[NUM_CAUSE-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         vec_q  <= '0;
         en_q   <= '0;
      end else if (reg_we) begin
         if (reg_addr == REG_CTRL) mode_q <= reg_wdata[0];
         if (reg_addr == REG_VEC)  vec_q  <= reg_wdata[NUM_CAUSE*VEC_W-1:0];
         if (reg_addr == REG_EN)   en_q   <= reg_wdata[NUM_CAUSE-1:0];
      end
   end

   always_comb begin
      if (tbl_hit)                    reg_rdata = tbl_rdata;
      else if (reg_addr == REG_CTRL)  reg_rdata = {31'd0, mode_q};
      else if (reg_addr == REG_PEND)  reg_rdata = 32'(pending);
      else if (reg_addr == REG_VEC)   reg_rdata = 32'(vec_q);
      else if (reg_addr == REG_EN)    reg_rdata = 32'(en_q);
      else                            reg_rdata = '0;
   end

   always_comb begin
      for (int c = 0; c < NUM_CAUSE; c++)
         eligible[c] = queued[c] && pending[c] && en_q[c] &&
                       !mask_vec[vec_q[c*VEC_W +: VEC_W]];
   end

   irqr_pending u_pending (
      .clk, .rst_n, .src_pulse, .clr,
      .msg_mode   (mode_q),
      .sent, .sent_cause, .pending, .queued
   );

   irqr_wired_map #(.VEC_W(VEC_W)) u_wired (
      .clk, .rst_n, .pending,
      .enable   (en_q),
      .vec      (vec_q),
      .msg_mode (mode_q),
      .wire_irq
   );

   irqr_msg_table #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
      .clk, .rst_n,
      .wr_en    (reg_we && tbl_hit),
      .wr_idx   (tbl_off[VEC_W+1:2]),
      .wr_field (tbl_off[1:0]),
      .wr_data  (reg_wdata),
      .rd_idx   (tbl_off[VEC_W+1:2]),
      .rd_field (tbl_off[1:0]),
      .rd_data  (tbl_rdata),
      .mask_vec,
      .sel_idx  (vec_q[pick*VEC_W +: VEC_W]),
      .sel_addr (pick_addr),
      .sel_data (pick_data)
   );

   irqr_msg_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
      .clk, .rst_n,
      .msg_mode (mode_q),
      .eligible, .pick, .pick_addr, .pick_data,
      .msg_valid, .msg_ready, .msg_addr, .msg_data,
      .sent, .sent_cause
   );
endmodule

// File: tb/irq_vec_router_test.sv
module irq_vec_router_test;
   localparam int NW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_pulse = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NW-1:0] wire_irq;
   logic        msg_valid;
   logic        msg_ready = 1'b0;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;

   always #10 clk = ~clk;

   irq_vec_router uut (
      .clk, .rst_n, .src_pulse, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .wire_irq, .msg_valid, .msg_ready, .msg_addr, .msg_data
   );

   int checks = 0;
   int errors = 0;
   logic [31:0] sent_log [$];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit          m_mode;
   int          m_vec [4];
   bit [3:0]    m_en, m_pend, m_q;
   logic [63:0] m_ta [16];
   logic [31:0] m_td [16];
   bit          m_tm [16];
   bit          m_valid;
   int          m_cause, m_ptr;
   logic [63:0] m_addr;
   logic [31:0] m_data;

   always @(posedge clk) begin
      bit hs, rise, clrb;
      int ch, c, e, f;
      bit [3:0] np, nq;
      if (!rst_n) begin
         m_mode = 0; m_en = 0; m_pend = 0; m_q = 0; m_valid = 0;
         m_cause = 0; m_ptr = 0; m_addr = 0; m_data = 0;
         for (int i = 0; i < 4; i++) m_vec[i] = 0;
         for (int i = 0; i < 16; i++) begin m_ta[i] = 0; m_td[i] = 0; m_tm[i] = 0; end
      end else begin
         hs = m_valid && msg_ready;
         ch = -1;
         if (!m_valid && m_mode)
            for (int k = 0; k < 4; k++) begin
               c = (m_ptr + k) % 4;
               if (ch < 0 && m_q[c] && m_pend[c] && m_en[c] && !m_tm[m_vec[c]]) ch = c;
            end
         for (int i = 0; i < 4; i++) begin
            rise  = src_pulse[i] && !m_pend[i];
            clrb  = reg_we && reg_addr == 8'h01 && reg_wdata[i];
            np[i] = (m_pend[i] && !clrb) || src_pulse[i];
            nq[i] = ((m_q[i] && !(hs && m_cause == i)) || (rise && m_mode)) && np[i];
         end
         if (m_valid) begin
            if (hs) begin m_valid = 0; m_ptr = (m_cause + 1) % 4; end
         end else if (ch >= 0) begin
            m_valid = 1; m_cause = ch;
            m_addr = m_ta[m_vec[ch]]; m_data = m_td[m_vec[ch]];
         end
         m_pend = np; m_q = nq;
         if (reg_we) begin
            if (reg_addr == 8'h00) m_mode = reg_wdata[0];
            if (reg_addr == 8'h02) for (int i = 0; i < 4; i++) m_vec[i] = int'(reg_wdata[4*i +: 4]);
            if (reg_addr == 8'h03) m_en = reg_wdata[3:0];
            if (reg_addr >= 8'h40 && reg_addr < 8'h80) begin
               e = (int'(reg_addr) - 64) / 4; f = int'(reg_addr) % 4;
               case (f)
                  0: m_ta[e][31:0]  = reg_wdata;
                  1: m_ta[e][63:32] = reg_wdata;
                  2: m_td[e]        = reg_wdata;
                  default: m_tm[e]  = reg_wdata[0];
               endcase
            end
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      logic [NW-1:0] ew;
      if (rst_n) begin
         ew = '0;
         for (int c = 0; c < 4; c++)
            if (m_pend[c] && m_en[c] && !m_mode) ew[m_vec[c]] = 1'b1;
         chk(wire_irq == ew, m_mode ? "R4 wires in message mode" : "R3 wire map", 64'(wire_irq), 64'(ew));
         chk(msg_valid == m_valid, "R6 valid vs model", 64'(msg_valid), 64'(m_valid));
         if (m_valid) begin
            chk(msg_addr == m_addr, "R6 address vs model", msg_addr, m_addr);
            chk(msg_data == m_data, "R6 data vs model", 64'(msg_data), 64'(m_data));
         end
      end
   end

   always @(negedge clk) begin
      #5;
      if (rst_n && msg_valid && msg_ready) sent_log.push_back(msg_data);
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); #2; reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); #2; reg_we = 0;
   endtask

   task automatic pulse(input logic [3:0] m);
      @(negedge clk); #2; src_pulse = m;
      @(negedge clk); #2; src_pulse = '0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); #2; reg_addr = a; #3;
      chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] ta(input int i, input int f);
      return 8'(64 + 4 * i + f);
   endfunction

   initial begin
      int cyc;
      cyc = 0;
      while (cyc < 150000) begin @(posedge clk); cyc++; end
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #2; rst_n = 1;
      idle(1);
      // R1 reset state
      chk(wire_irq == '0, "R1 wires after reset", 64'(wire_irq), 0);
      chk(msg_valid == 0, "R1 valid after reset", 64'(msg_valid), 0);
      rd(8'h01, 0, "R1 pending after reset");
      rd(ta(5, 3), 0, "R1 table mask after reset");

      // wired mode sharing: cmd,page->3 fault->7 perf->15
      wr(8'h02, 32'hF733);
      wr(8'h03, 32'hF);
      pulse(4'b0001); idle(1);
      chk(wire_irq == 16'h0008, "R3 cmd on wire 3", 64'(wire_irq), 64'h8);
      pulse(4'b0010);
      wr(8'h01, 32'h1); idle(1);
      chk(wire_irq == 16'h0008, "R3 shared wire held by page", 64'(wire_irq), 64'h8);
      wr(8'h01, 32'h2); idle(1);
      chk(wire_irq == 16'h0000, "R3 wire low after clears", 64'(wire_irq), 0);
      pulse(4'b1100); idle(1);
      chk(wire_irq == 16'h8080, "R3 fault and perf wires", 64'(wire_irq), 64'h8080);
      // disabled cause stays pending but drives nothing
      wr(8'h03, 32'hB); idle(1);
      chk(wire_irq == 16'h8000, "R3 disabled fault", 64'(wire_irq), 64'h8000);
      rd(8'h01, 32'hC, "R2 pending held while disabled");
      wr(8'h03, 32'hF);
      // R2 clash: pulse and clear of page in same cycle
      pulse(4'b0010);
      @(negedge clk); #2; reg_we = 1; reg_addr = 8'h01; reg_wdata = 32'h2; src_pulse = 4'b0010;
      @(negedge clk); #2; reg_we = 0; src_pulse = '0;
      rd(8'h01, 32'hE, "R2 set wins over clear");
      wr(8'h01, 32'h6);
      rd(8'h01, 32'h8, "R2 write-one clears");
      rd(8'h02, 32'hF733, "R9 vector readback");

      // table programming R10
      for (int i = 0; i < 16; i++) begin
         wr(ta(i, 0), 32'hA000_0000 + i);
         wr(ta(i, 1), 32'h0000_1000 + i);
         wr(ta(i, 2), 32'hD000_0000 + i);
      end
      rd(ta(3, 0), 32'hA000_0003, "R10 address low");
      rd(ta(3, 1), 32'h0000_1003, "R10 address high");
      rd(ta(3, 2), 32'hD000_0003, "R10 data");
      wr(ta(9, 3), 1);
      rd(ta(9, 3), 1, "R10 mask bit");
      wr(ta(9, 3), 0);

      // message mode with perf pending: wires drop, nothing queued
      wr(8'h00, 1); idle(1);
      chk(wire_irq == '0, "R4 wires low in message mode", 64'(wire_irq), 0);
      idle(4);
      chk(msg_valid == 0, "R5 no message for prior pending", 64'(msg_valid), 0);
      wr(8'h01, 32'hF);

      // one message, held by ready low
      msg_ready = 0;
      pulse(4'b0001); idle(3);
      chk(msg_valid == 1, "R5 message raised", 64'(msg_valid), 1);
      chk(msg_data == 32'hD000_0003, "R6 data from entry 3", 64'(msg_data), 64'hD000_0003);
      idle(5);
      chk(msg_addr == 64'h0000_1003_A000_0003, "R6 address held", msg_addr, 64'h0000_1003_A000_0003);
      sent_log.delete();
      @(negedge clk); #2; msg_ready = 1;
      @(negedge clk); #2; msg_ready = 0;
      idle(1);
      chk(msg_valid == 0, "R8 valid drops after handshake", 64'(msg_valid), 0);
      chk(sent_log.size() == 1, "R5 one message sent", 64'(sent_log.size()), 1);
      msg_ready = 1;
      pulse(4'b0001); idle(6);
      chk(sent_log.size() == 1, "R5 repeat pulse while pending", 64'(sent_log.size()), 1);
      wr(8'h01, 32'hF);

      // round robin: distinct vectors 1,2,4,8; pointer now at cause 1
      wr(8'h02, 32'h8421);
      sent_log.delete();
      pulse(4'b1111); idle(20);
      chk(sent_log.size() == 4, "R8 four messages", 64'(sent_log.size()), 4);
      if (sent_log.size() == 4) begin
         chk(sent_log[0] == 32'hD000_0002, "R8 first page", 64'(sent_log[0]), 64'hD000_0002);
         chk(sent_log[1] == 32'hD000_0004, "R8 second fault", 64'(sent_log[1]), 64'hD000_0004);
         chk(sent_log[2] == 32'hD000_0008, "R8 third perf", 64'(sent_log[2]), 64'hD000_0008);
         chk(sent_log[3] == 32'hD000_0001, "R8 last cmd", 64'(sent_log[3]), 64'hD000_0001);
      end
      wr(8'h01, 32'hF);

      // masked entry holds the fault message
      sent_log.delete();
      wr(ta(4, 3), 1);
      pulse(4'b0100); idle(6);
      chk(sent_log.size() == 0, "R7 masked entry holds", 64'(sent_log.size()), 0);
      wr(ta(4, 3), 0); idle(4);
      chk(sent_log.size() == 1, "R7 sent after unmask", 64'(sent_log.size()), 1);
      wr(8'h01, 32'h4);
      // masked then cleared: dropped
      sent_log.delete();
      wr(ta(4, 3), 1);
      pulse(4'b0100);
      wr(8'h01, 32'h4);
      wr(ta(4, 3), 0); idle(6);
      chk(sent_log.size() == 0, "R7 dropped after clear", 64'(sent_log.size()), 0);
      rd(8'h02, 32'h8421, "R9 vector unchanged by traffic");

      // back to wired mode with a shared wire
      wr(8'h00, 0);
      wr(8'h02, 32'h5555);
      pulse(4'b1001); idle(1);
      chk(wire_irq == 16'h0020, "R3 all causes on wire 5", 64'(wire_irq), 64'h20);
      idle(2);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule